// File: doc/BRIEF.md
# Eight-Lane Block SAD Engine

This block measures how far apart two 8x8 blocks of unsigned 8-bit pixels are. The measure is the sum of absolute differences (SAD) over all 64 positions. Each clock the caller presents one line of eight pixel pairs, one row from the predicted block and the matching row from the reference block. Eight parallel lanes each take the absolute difference of one pair. A registered binary adder tree reduces the eight lane results to one row sum. An accumulator adds eight such row sums into the block result. A block therefore takes eight data cycles. A single clear cycle then empties the accumulator before the next block starts, so a stream of blocks runs at nine cycles per block.

The valid and clear strobes travel through a delay line that matches the lane and tree registers. Each strobe therefore reaches the accumulator together with the row sum it belongs to. The accumulator is a three-state machine. EMPTY holds no rows. FILLING holds one to seven rows. FULL holds a finished block. The transitions are: EMPTY to FILLING on the first accepted row; FILLING to FILLING on each further row up to the seventh; FILLING to FULL on the eighth row, which also raises the done strobe; any state to EMPTY on an aligned clear; FULL to FULL on any row, which is discarded.

Top module: `sad_row_engine`

## Requirements
- R1: During and after reset, `sad_done` is 0 and `sad_out` is 0, and the accumulator is EMPTY.
- R2: `sad_out` equals the sum, over the eight accepted rows and eight lanes, of |pred - ref|. Lane i occupies bits [8i+7:8i] of `pred_row` and `ref_row`.
- R3: The largest possible result, 64 x 255 = 16320, is reported exactly on the 14-bit `sad_out`, with no wrap.
- R4: `sad_done` is high for exactly one cycle. It rises after the fifth rising edge counted from, and including, the edge that samples the eighth accepted row.
- R5: A cycle with `row_vld` low adds nothing, whatever the pixel inputs carry. Such idle cycles may fall anywhere between the rows of a block.
- R6: `row_clr` discards any partial or finished block and returns the accumulator to EMPTY. A row presented together with a clear is dropped.
- R7: Once a block is FULL, further valid rows before a clear cause no done pulse and leave `sad_out` unchanged.
- R8: `sad_out` holds its last result until the next done pulse.
- R9: Blocks separated by exactly one clear cycle complete back to back, with done pulses nine cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| row_vld | input | 1 | A row pair is present this cycle |
| row_clr | input | 1 | Synchronous clear of the accumulator, aligned with the row stream |
| pred_row | input | 64 | Eight predicted-block pixels, lane i in bits [8i+7:8i] |
| ref_row | input | 64 | Eight reference-block pixels, same lane layout |
| sad_out | output | 14 | SAD of the last completed block |
| sad_done | output | 1 | One-cycle strobe: `sad_out` has just been updated |

## Verification
The bench aims at five corner cases, each of which a faulty design would get wrong in a visible way.
- Latency: if a strobe is delayed out of step with the row sums, the done pulse comes a cycle early or late, or a row is added twice or lost.
- Idle cycles: random data on idle cycles exposes a design that adds row sums while `row_vld` is low.
- Clears: a clear in mid-block, and a clear presented in the same cycle as a valid row, expose a design that keeps stale partial sums or counts the dropped row.
- Extra rows: sending ten rows before a clear catches a design that wraps its row count and produces a second, wrong result.
- Full scale: an all-255 against all-0 block catches a result register that is too narrow, which would wrap to a small value.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_LANES = 8;
    localparam int DEF_ROWS  = 8;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_FILLING = 2'd1,
        S_FULL    = 2'd2
    } acc_state_e;
endpackage

// File: rtl/sad_absdiff_lane.sv
module sad_absdiff_lane #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] d_o
);
    logic [PIX_W-1:0] diff;

    always_comb begin
        if (a_i >= b_i) diff = a_i - b_i;
        else            diff = b_i - a_i;
    end

    always_ff @(posedge clk) begin
        if (rst) d_o <= '0;
        else     d_o <= diff;
    end
endmodule

// File: rtl/sad_adder_tree.sv
module sad_adder_tree #(
    parameter int PIX_W = 8,
    parameter int LANES = 8,
    localparam int LEVELS = $clog2(LANES),
    localparam int SUM_W  = PIX_W + LEVELS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*PIX_W-1:0] leaf_i,
    output logic [SUM_W-1:0]       sum_o
);
    localparam int LEAF_MAX = (1 << PIX_W) - 1;

    for (genvar l = 0; l <= LEVELS; l++) begin : lvl_g
        localparam int N = LANES >> l;
        logic [SUM_W-1:0] node [N];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_in
                assign node[j] = {{LEVELS{1'b0}}, leaf_i[j*PIX_W +: PIX_W]};
            end
        end else begin : g_add
            for (genvar j = 0; j < N; j++) begin : g_pair
                always_ff @(posedge clk) begin
                    if (rst) node[j] <= '0;
                    else     node[j] <= lvl_g[l-1].node[2*j] + lvl_g[l-1].node[2*j+1];
                end
            end
        end
    end

    assign sum_o = lvl_g[LEVELS].node[0];

    // R3: a row sum never exceeds eight full-scale differences
    assert_row_sum_bound_R3: assert property (@(posedge clk) disable iff (rst)
        sum_o <= SUM_W'(LANES * LEAF_MAX));
endmodule

// File: rtl/sad_accum_ctrl.sv
module sad_accum_ctrl
    import sad_pkg::*;
#(
    parameter int SUM_W = 11,
    parameter int SAD_W = 14,
    parameter int ROWS  = 8,
    parameter int DLY   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             clr_i,
    input  logic [SUM_W-1:0] row_sum_i,
    output logic [SAD_W-1:0] sad_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(ROWS + 1);
    localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(ROWS - 1);

    logic [DLY-1:0] vld_sr, clr_sr;
    logic           vld_al, clr_al, take;
    acc_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [SAD_W-1:0] acc_q, acc_sum;

    // strobe delay line matching the lane and tree registers
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
            clr_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[DLY-2:0], vld_i};
            clr_sr <= {clr_sr[DLY-2:0], clr_i};
        end
    end

    assign vld_al  = vld_sr[DLY-1];
    assign clr_al  = clr_sr[DLY-1];
    assign take    = vld_al && !clr_al && (state_q != S_FULL);
    assign acc_sum = acc_q + {{(SAD_W-SUM_W){1'b0}}, row_sum_i};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY, S_FILLING: begin
                if (clr_al)                          state_d = S_EMPTY;
                else if (take && cnt_q == LAST_ROW)  state_d = S_FULL;
                else if (take)                       state_d = S_FILLING;
            end
            S_FULL: begin
                if (clr_al) state_d = S_EMPTY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            sad_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (clr_al) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (take) begin
                acc_q <= acc_sum;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_ROW) begin
                    sad_o  <= acc_sum;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4: the done strobe lasts one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R7: a block that stays full raises no further done
    assert_full_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FULL && $past(state_q == S_FULL)) |-> !done_o);
    // R8: the result moves only with a done pulse
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> sad_o == $past(sad_o));
    // R6: an empty accumulator carries no row count
    assert_empty_no_rows_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == S_EMPTY |-> cnt_q == '0);
endmodule

// File: rtl/sad_row_engine.sv
module sad_row_engine
    import sad_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int LANES = DEF_LANES,
    parameter int ROWS  = DEF_ROWS,
    localparam int MAX_SAD = ROWS * LANES * ((1 << PIX_W) - 1),
    localparam int SAD_W   = $clog2(MAX_SAD + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   row_vld,
    input  logic                   row_clr,
    input  logic [LANES*PIX_W-1:0] pred_row,
    input  logic [LANES*PIX_W-1:0] ref_row,
    output logic [SAD_W-1:0]       sad_out,
    output logic                   sad_done
);
    localparam int LEVELS = $clog2(LANES);
    localparam int SUM_W  = PIX_W + LEVELS;
    localparam int DLY    = LEVELS + 1;

    logic [LANES*PIX_W-1:0] lane_d;
    logic [SUM_W-1:0]       row_sum;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sad_absdiff_lane #(.PIX_W(PIX_W)) u_lane (
            .clk (clk),
            .rst (rst),
            .a_i (pred_row[i*PIX_W +: PIX_W]),
            .b_i (ref_row[i*PIX_W +: PIX_W]),
            .d_o (lane_d[i*PIX_W +: PIX_W])
        );
    end

    sad_adder_tree #(.PIX_W(PIX_W), .LANES(LANES)) u_tree (
        .clk    (clk),
        .rst    (rst),
        .leaf_i (lane_d),
        .sum_o  (row_sum)
    );

    sad_accum_ctrl #(.SUM_W(SUM_W), .SAD_W(SAD_W), .ROWS(ROWS), .DLY(DLY)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .vld_i     (row_vld),
        .clr_i     (row_clr),
        .row_sum_i (row_sum),
        .sad_o     (sad_out),
        .done_o    (sad_done)
    );

    // R3: the reported result stays within full scale
    assert_result_range_R3: assert property (@(posedge clk) disable iff (rst)
        sad_out <= SAD_W'(MAX_SAD));
endmodule

// File: tb/sim_sad_row_engine.sv
`timescale 1ns/1ps
module sim_sad_row_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        row_vld = 1'b0;
    logic        row_clr = 1'b0;
    logic [63:0] pred_row = '0;
    logic [63:0] ref_row = '0;
    logic [13:0] sad_out;
    logic        sad_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    sad_row_engine u0 (
        .clk(clk), .rst(rst), .row_vld(row_vld), .row_clr(row_clr),
        .pred_row(pred_row), .ref_row(ref_row),
        .sad_out(sad_out), .sad_done(sad_done)
    );

    function automatic int rsum(input logic [63:0] p, input logic [63:0] r);
        int s = 0;
        for (int i = 0; i < 8; i++) begin
            int a = int'(p[8*i +: 8]);
            int b = int'(r[8*i +: 8]);
            s += (a > b) ? a - b : b - a;
        end
        return s;
    endfunction

    // behavioural reference: strobes and row sums reach the result four edges later
    bit qv[4], qc[4];
    int qs[4];
    bit m_full;
    int m_cnt, m_acc, exp_sad;
    bit exp_done;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin qv[k] = 0; qc[k] = 0; qs[k] = 0; end
            m_full = 0; m_cnt = 0; m_acc = 0; exp_sad = 0; exp_done = 0;
        end else begin
            bit ov, oc;
            int os;
            ov = qv[3]; oc = qc[3]; os = qs[3];
            for (int k = 3; k > 0; k--) begin qv[k] = qv[k-1]; qc[k] = qc[k-1]; qs[k] = qs[k-1]; end
            qv[0] = row_vld; qc[0] = row_clr; qs[0] = rsum(pred_row, ref_row);
            exp_done = 0;
            if (oc) begin
                m_acc = 0; m_cnt = 0; m_full = 0;
            end else if (ov && !m_full) begin
                m_acc += os;
                m_cnt++;
                if (m_cnt == 8) begin m_full = 1; exp_sad = m_acc; exp_done = 1; end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison; the done tag is R4, the value tag follows the scenario
    bit track_gap = 0;
    int last_done = -1;
    always @(negedge clk) begin
        cyc++;
        if (!rst && !finished) begin
            check("R4", "sad_done", int'(sad_done), int'(exp_done));
            check(cur_req, "sad_out", int'(sad_out), exp_sad);
            if (sad_done) begin
                if (track_gap && last_done >= 0) check("R9", "done spacing", cyc - last_done, 9);
                last_done = cyc;
            end
        end
    end

    task automatic put(input bit v, input bit c, input logic [63:0] p, input logic [63:0] r);
        @(negedge clk);
        row_vld = v; row_clr = c; pred_row = p; ref_row = r;
    endtask

    task automatic rnd_idle();
        put(0, 0, {$urandom, $urandom}, {$urandom, $urandom});
    endtask

    task automatic send_block(input int bubble_pct, output int total);
        total = 0;
        for (int row = 0; row < 8; row++) begin
            logic [63:0] p, r;
            while (($urandom % 100) < bubble_pct) rnd_idle();
            p = {$urandom, $urandom};
            r = {$urandom, $urandom};
            total += rsum(p, r);
            put(1, 0, p, r);
        end
    endtask

    task automatic wait_done(input string req, input int exp);
        bit seen = 0;
        for (int n = 0; n < 20 && !seen; n++) begin
            put(0, 0, '0, '0);
            if (sad_done) seen = 1;
        end
        check(req, "done seen", int'(seen), 1);
        if (seen) check(req, "block sad", int'(sad_out), exp);
    endtask

    initial begin
        int tot;
        repeat (4) @(negedge clk);
        // R1: reset values
        check("R1", "sad_out in reset", int'(sad_out), 0);
        check("R1", "sad_done in reset", int'(sad_done), 0);
        rst = 1'b0;
        put(0, 0, '0, '0);
        check("R1", "sad_out after reset", int'(sad_out), 0);

        // R2: random block, lane i at bits [8i+7:8i]
        cur_req = "R2";
        send_block(0, tot);
        wait_done("R2", tot);
        put(0, 1, '0, '0);

        // R3: full-scale block
        cur_req = "R3";
        for (int k = 0; k < 8; k++) put(1, 0, {64{1'b1}}, '0);
        wait_done("R3", 16320);
        put(0, 1, '0, '0);

        // zero-difference block
        cur_req = "R2";
        for (int k = 0; k < 8; k++) put(1, 0, 64'h5A5A_1234_FF00_0077, 64'h5A5A_1234_FF00_0077);
        wait_done("R2", 0);
        put(0, 1, '0, '0);

        // R5: idle cycles with random data between rows
        cur_req = "R5";
        send_block(50, tot);
        wait_done("R5", tot);
        put(0, 1, '0, '0);

        // R6: clear mid-block, then a valid row together with a clear is dropped
        cur_req = "R6";
        for (int k = 0; k < 3; k++) put(1, 0, {64{1'b1}}, '0);
        put(0, 1, '0, '0);
        put(1, 1, {64{1'b1}}, '0);
        send_block(0, tot);
        wait_done("R6", tot);
        put(0, 1, '0, '0);

        // R7 and R8: ten rows; the two extras change nothing
        cur_req = "R7";
        send_block(0, tot);
        put(1, 0, {64{1'b1}}, '0);
        put(1, 0, {64{1'b1}}, '0);
        wait_done("R7", tot);
        repeat (8) put(1, 0, {64{1'b1}}, '0);
        check("R7", "no done on extra rows", int'(sad_done), 0);
        put(0, 0, '0, '0);
        repeat (6) put(0, 0, '0, '0);
        check("R8", "result held", int'(sad_out), tot);
        put(0, 1, '0, '0);

        // R9: back-to-back blocks, one clear cycle apart
        cur_req = "R9";
        track_gap = 1; last_done = -1;
        for (int b = 0; b < 4; b++) begin
            send_block(0, tot);
            put(0, 1, '0, '0);
        end
        repeat (8) put(0, 0, '0, '0);
        track_gap = 0;

        // mixed random traffic checked against the reference every cycle
        cur_req = "R2";
        for (int b = 0; b < 30; b++) begin
            send_block(20, tot);
            if ($urandom % 4 == 0) rnd_idle();
            put(0, 1, '0, '0);
        end
        repeat (10) put(0, 0, '0, '0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule